// File: doc/BRIEF.md
# Multi-Channel PWM with Period-Aligned Duty Updates

This block generates a set of independent pulse-width modulated outputs from one input clock. Each channel counts prescaled ticks through a programmable period. Its output sits at the active level for the part of the period in which the tick count has reached the duty value. The prescale factor is a power of two, and each channel has its own polarity. Software reaches the channels through a small synchronous register bus. Channels start and stop through two write-one mask registers.

A duty value can be written in two ways. A direct write changes the active duty at once. A queued write is held in a per-channel staging register and moves into the active duty only at the next period start, so the waveform never shows a period that is half old and half new. A shared read-to-clear status register carries one bit per channel and marks every period start. Software can poll it to learn when a queued duty has taken effect, for example before it stops a channel whose last queued duty was zero.

Top module: `pwm_bank`

## Requirements
- R1: A write to a channel's queued-duty register (channel offset 3) leaves the active duty and the output unchanged for the rest of the running period.
- R2: At the next period start of that channel, the queued value becomes the active duty, and it reads back from the active-duty register (channel offset 2).
- R3: Every period start of a channel sets that channel's bit in the status register (address 0x02, bit n for channel n). The start caused by an enable counts as a period start.
- R4: A read of the status register returns all channel bits and clears all of them in the same access.
- R5: Writing a mask to address 0x00 starts each listed channel that is stopped. Writing a mask to address 0x01 stops each listed channel. A zero bit leaves its channel as it was, and an enable of a channel that is already running has no effect.
- R6: A channel's period lasts P * 2^E input clocks, where P is its period register (offset 1) and E is the exponent in bits 3:0 of its mode register (offset 0).
- R7: The output is active while the tick count within the period is at least the duty value D, which gives P - D active ticks. With D >= P the output never goes active, and with D = 0 it stays active all the time.
- R8: If a channel starts a period in the same cycle as a status read, that channel's bit is still set after the read.
- R9: A stopped channel drives its inactive level and never sets its status bit. The output reaches the active level (or stays inactive) one clock after the enable write, because the count restarts at zero at that write.
- R10: Direct writes to a channel's period and active-duty registers take effect at once. A queued duty that is pending when a stopped channel is enabled becomes active at the start caused by that enable.
- R11: Bit 4 of the mode register selects polarity: 1 means the active level is high, 0 means it is low. The bit resets to 1.
- R12: The registers of channel n sit at 0x10 + 4n + offset. Read data appears on the clock after the read strobe. After reset every channel is stopped, its output is low, and its period and duty are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 8 | Register word address |
| bus_we | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (status is cleared on read) |
| bus_wdata | input | PW | Write data |
| bus_rdata | output | PW | Registered read data |
| pwm_o | output | NCH | PWM outputs, one per channel |

## Verification
On every cycle, the checker confirms four things. A queued-duty write never changes the active duty outside a period start. Status bits follow the period-start events exactly across a clearing read, including an event in the same cycle. An enable of a stopped channel always produces a start. A stopped channel stays silent and inactive. The measured properties need whole waveforms and are left to the directed scenarios: period length under prescaling, active-time counts, the duty limits, polarity, mask independence between channels, and the moment a queued duty lands.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  localparam int ADDR_W = 8;
  localparam int OFS_W  = 2;

  localparam logic [ADDR_W-1:0] A_ENA     = 8'h00;
  localparam logic [ADDR_W-1:0] A_DIS     = 8'h01;
  localparam logic [ADDR_W-1:0] A_STAT    = 8'h02;
  localparam int                CH_BASE   = 16;

  typedef enum logic [OFS_W-1:0] {
    CR_MODE = 2'd0,
    CR_PER  = 2'd1,
    CR_DUTY = 2'd2,
    CR_NEXT = 2'd3
  } ch_reg_e;

  function automatic logic [ADDR_W-1:0] ch_addr(int ch, ch_reg_e r);
    return ADDR_W'(CH_BASE + 4 * ch + int'(r));
  endfunction

endpackage

// File: rtl/pwm_chan.sv
module pwm_chan #(
  parameter int PW    = 16,
  parameter int PRE_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_set,
  input  logic             en_clr,
  input  logic             wr_mode,
  input  logic             wr_per,
  input  logic             wr_duty,
  input  logic             wr_next,
  input  logic [PW-1:0]    wdata,
  output logic             run,
  output logic             pol,
  output logic [PRE_W-1:0] pre,
  output logic [PW-1:0]    period,
  output logic [PW-1:0]    duty,
  output logic [PW-1:0]    dnext,
  output logic             start,
  output logic             pwm_o
);

  localparam int PSW = (1 << PRE_W) - 1;

  logic [PSW-1:0] pcnt;
  logic [PSW-1:0] ps_lim;
  logic [PW-1:0]  cnt;
  logic [PW:0]    cnt_nx;
  logic           pend;
  logic           tick_end;
  logic           wrap;

  // last prescaler phase of a tick is 2^E - 1
  assign ps_lim   = PSW'((32'd1 << pre) - 32'd1);
  assign tick_end = (pcnt == ps_lim);
  assign cnt_nx   = {1'b0, cnt} + {{PW{1'b0}}, 1'b1};
  assign wrap     = (cnt_nx >= {1'b0, period});
  assign start    = (en_set && !run) || (run && tick_end && wrap);

  always_ff @(posedge clk) begin
    if (rst) begin
      run    <= 1'b0;
      pcnt   <= '0;
      cnt    <= '0;
      pol    <= 1'b1;
      pre    <= '0;
      period <= '0;
      duty   <= '0;
      dnext  <= '0;
      pend   <= 1'b0;
      pwm_o  <= 1'b0;
    end else begin
      if (wr_mode) begin
        pol <= wdata[PRE_W];
        pre <= wdata[PRE_W-1:0];
      end
      if (wr_per)  period <= wdata;
      if (wr_duty) duty   <= wdata;

      if (start) begin
        pcnt <= '0;
        cnt  <= '0;
        if (pend) begin
          duty <= dnext;
          pend <= 1'b0;
        end
      end else if (run) begin
        if (tick_end) begin
          pcnt <= '0;
          cnt  <= cnt_nx[PW-1:0];
        end else begin
          pcnt <= pcnt + 1'b1;
        end
      end

      if (en_set) run <= 1'b1;
      if (en_clr) begin
        run  <= 1'b0;
        pcnt <= '0;
        cnt  <= '0;
      end

      // a queue write in a start cycle lands at the following start
      if (wr_next) begin
        dnext <= wdata;
        pend  <= 1'b1;
      end

      pwm_o <= (run && (cnt >= duty)) ? pol : !pol;
    end
  end

endmodule

// File: rtl/pwm_regif.sv
module pwm_regif
  import pwm_pkg::*;
#(
  parameter int NCH = 4,
  parameter int PW  = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic                   bus_we,
  input  logic                   bus_rd,
  input  logic [PW-1:0]          bus_wdata,
  output logic [PW-1:0]          bus_rdata,
  input  logic [NCH-1:0]         start_v,
  input  logic [NCH-1:0][PW-1:0] mode_a,
  input  logic [NCH-1:0][PW-1:0] per_a,
  input  logic [NCH-1:0][PW-1:0] duty_a,
  input  logic [NCH-1:0][PW-1:0] next_a,
  output logic [NCH-1:0]         en_set,
  output logic [NCH-1:0]         en_clr,
  output logic [NCH-1:0]         wr_mode,
  output logic [NCH-1:0]         wr_per,
  output logic [NCH-1:0]         wr_duty,
  output logic [NCH-1:0]         wr_next,
  output logic [NCH-1:0]         stat_q
);

  logic [PW-1:0] rmux;
  logic          stat_rd;

  assign en_set  = (bus_we && bus_addr == A_ENA) ? bus_wdata[NCH-1:0] : '0;
  assign en_clr  = (bus_we && bus_addr == A_DIS) ? bus_wdata[NCH-1:0] : '0;
  assign stat_rd = bus_rd && (bus_addr == A_STAT);

  for (genvar i = 0; i < NCH; i++) begin : g_dec
    localparam logic [ADDR_W-1:0] BASE = ch_addr(i, CR_MODE);
    logic hit;
    assign hit        = bus_we && (bus_addr[ADDR_W-1:OFS_W] == BASE[ADDR_W-1:OFS_W]);
    assign wr_mode[i] = hit && (ch_reg_e'(bus_addr[OFS_W-1:0]) == CR_MODE);
    assign wr_per[i]  = hit && (ch_reg_e'(bus_addr[OFS_W-1:0]) == CR_PER);
    assign wr_duty[i] = hit && (ch_reg_e'(bus_addr[OFS_W-1:0]) == CR_DUTY);
    assign wr_next[i] = hit && (ch_reg_e'(bus_addr[OFS_W-1:0]) == CR_NEXT);
  end

  always_comb begin
    rmux = '0;
    if (bus_addr == A_STAT) rmux = PW'(stat_q);
    for (int i = 0; i < NCH; i++) begin
      if (bus_addr == ch_addr(i, CR_MODE)) rmux = mode_a[i];
      if (bus_addr == ch_addr(i, CR_PER))  rmux = per_a[i];
      if (bus_addr == ch_addr(i, CR_DUTY)) rmux = duty_a[i];
      if (bus_addr == ch_addr(i, CR_NEXT)) rmux = next_a[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      stat_q    <= '0;
    end else begin
      if (bus_rd) bus_rdata <= rmux;
      // events of the read cycle survive the clear
      if (stat_rd) stat_q <= start_v;
      else         stat_q <= stat_q | start_v;
    end
  end

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int PW    = 16,
  parameter int PRE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic              bus_rd,
  input  logic [PW-1:0]     bus_wdata,
  output logic [PW-1:0]     bus_rdata,
  output logic [NCH-1:0]    pwm_o
);

  // NCH must lie in 1..8 and PW must be at least max(NCH, PRE_W + 1)

  logic [NCH-1:0]            start_v, run_v, pol_v;
  logic [NCH-1:0]            en_set, en_clr, wr_mode, wr_per, wr_duty, wr_next;
  logic [NCH-1:0]            stat_q;
  logic [NCH-1:0][PRE_W-1:0] pre_a;
  logic [NCH-1:0][PW-1:0]    mode_a, per_a, duty_a, next_a;

  pwm_regif #(.NCH(NCH), .PW(PW)) i_regif (
    .clk(clk), .rst(rst),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .start_v(start_v), .mode_a(mode_a), .per_a(per_a),
    .duty_a(duty_a), .next_a(next_a),
    .en_set(en_set), .en_clr(en_clr), .wr_mode(wr_mode),
    .wr_per(wr_per), .wr_duty(wr_duty), .wr_next(wr_next),
    .stat_q(stat_q)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    pwm_chan #(.PW(PW), .PRE_W(PRE_W)) i_chan (
      .clk(clk), .rst(rst),
      .en_set(en_set[i]), .en_clr(en_clr[i]),
      .wr_mode(wr_mode[i]), .wr_per(wr_per[i]),
      .wr_duty(wr_duty[i]), .wr_next(wr_next[i]),
      .wdata(bus_wdata),
      .run(run_v[i]), .pol(pol_v[i]), .pre(pre_a[i]),
      .period(per_a[i]), .duty(duty_a[i]), .dnext(next_a[i]),
      .start(start_v[i]), .pwm_o(pwm_o[i])
    );
    assign mode_a[i] = PW'({pol_v[i], pre_a[i]});
  end

endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk
  import pwm_pkg::*;
#(
  parameter int NCH = 4,
  parameter int PW  = 16
) (
  input logic                   clk,
  input logic                   rst,
  input logic [ADDR_W-1:0]      bus_addr,
  input logic                   bus_we,
  input logic                   bus_rd,
  input logic [NCH-1:0]         wmask,
  input logic [NCH-1:0]         start_v,
  input logic [NCH-1:0]         run_v,
  input logic [NCH-1:0]         pol_v,
  input logic [NCH-1:0][PW-1:0] duty_a,
  input logic [NCH-1:0]         stat_q,
  input logic [NCH-1:0]         pwm_o
);

  // R4: the clearing read keeps exactly the events of its own cycle
  a_r4_read_clears: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == A_STAT) |=> (stat_q == $past(start_v)));

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    localparam logic [ADDR_W-1:0] NXT_A = ch_addr(i, CR_NEXT);

    a_r1_queue_holds: assert property (@(posedge clk) disable iff (rst)
      (bus_we && bus_addr == NXT_A && !start_v[i]) |=> $stable(duty_a[i]));

    a_r3_start_sets: assert property (@(posedge clk) disable iff (rst)
      start_v[i] |=> stat_q[i]);

    a_r8_event_kept: assert property (@(posedge clk) disable iff (rst)
      (bus_rd && bus_addr == A_STAT && start_v[i]) |=> stat_q[i]);

    a_r5_enable_starts: assert property (@(posedge clk) disable iff (rst)
      (bus_we && bus_addr == A_ENA && wmask[i] && !run_v[i]) |-> start_v[i]);

    a_r9_idle_silent: assert property (@(posedge clk) disable iff (rst)
      (!run_v[i] && !(bus_we && bus_addr == A_ENA && wmask[i])) |-> !start_v[i]);

    a_r9_idle_inactive: assert property (@(posedge clk) disable iff (rst)
      !run_v[i] |=> (pwm_o[i] == !$past(pol_v[i])));
  end

endmodule

bind pwm_bank pwm_bank_chk #(.NCH(NCH), .PW(PW)) i_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we), .bus_rd(bus_rd),
  .wmask(bus_wdata[NCH-1:0]), .start_v(start_v), .run_v(run_v), .pol_v(pol_v),
  .duty_a(duty_a), .stat_q(stat_q), .pwm_o(pwm_o)
);

// File: tb/test_pwm_bank.sv
module test_pwm_bank;

  localparam int CLK_P = 10;
  localparam int NCH   = 4;
  localparam int PW    = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [7:0]    bus_addr = '0;
  logic          bus_we = 1'b0;
  logic          bus_rd = 1'b0;
  logic [PW-1:0] bus_wdata = '0;
  logic [PW-1:0] bus_rdata;
  logic [NCH-1:0] pwm_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #(CLK_P/2) clk = ~clk;

  pwm_bank #(.NCH(NCH), .PW(PW), .PRE_W(4)) i_pwm_bank (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_o(pwm_o)
  );

  function automatic logic [7:0] ra(int ch, int ofs);
    return 8'(16 + 4 * ch + ofs);
  endfunction

  task automatic check(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, int d);
    @(negedge clk);
    bus_addr = a; bus_wdata = PW'(d); bus_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  // starts at a negedge, returns at the next negedge
  task automatic wr_now(logic [7:0] a, int d);
    bus_addr = a; bus_wdata = PW'(d); bus_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_now(logic [7:0] a, output int d);
    bus_addr = a; bus_rd = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_rd = 1'b0;
    d = int'(bus_rdata);
  endtask

  task automatic setup(int ch, int mode, int per, int duty);
    wr(ra(ch, 0), mode);
    wr(ra(ch, 1), per);
    wr(ra(ch, 2), duty);
  endtask

  task automatic t_reset();
    int d;
    @(negedge clk);
    check("R12 reset outputs low", int'(pwm_o), 0);
    rd_now(8'h02, d);
    check("R12 reset status", d, 0);
    rd_now(ra(0, 2), d);
    check("R12 reset duty", d, 0);
    rd_now(ra(1, 0), d);
    check("R11 reset mode polarity", d, 16);
  endtask

  task automatic t_prescale();
    int highs = 0, rises = 0, first = 0, second = 0;
    logic prev;
    wr(8'h01, 15);
    setup(0, 16 + 2, 5, 2);
    wr(8'h00, 1);
    prev = pwm_o[0];
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk);
      if (pwm_o[0]) highs++;
      if (pwm_o[0] && !prev) begin
        rises++;
        if (rises == 1) first = k;
        if (rises == 2) second = k;
      end
      prev = pwm_o[0];
    end
    check("R6 period with prescale 4", second - first, 20);
    check("R7 active clocks over two periods", highs, 24);
  endtask

  task automatic t_polarity();
    int lows = 0;
    wr(8'h01, 15);
    setup(0, 0, 8, 3);
    wr(8'h00, 1);
    for (int k = 1; k <= 16; k++) begin
      @(negedge clk);
      if (!pwm_o[0]) lows++;
    end
    check("R11 active-low clocks", lows, 10);
  endtask

  task automatic t_limits();
    int highs = 0;
    wr(8'h01, 15);
    setup(0, 16, 6, 6);
    wr(8'h00, 1);
    for (int k = 1; k <= 30; k++) begin
      @(negedge clk);
      if (pwm_o[0]) highs++;
    end
    check("R7 duty equal period never active", highs, 0);
    wr(8'h01, 1);
    wr(ra(0, 2), 0);
    wr_now(8'h00, 1);
    check("R9 no active level in enable cycle", int'(pwm_o[0]), 0);
    highs = 0;
    for (int k = 1; k <= 30; k++) begin
      @(negedge clk);
      if (pwm_o[0]) highs++;
    end
    check("R9 R7 duty zero active from first clock", highs, 30);
  endtask

  task automatic t_queue();
    int d, highs = 0;
    wr(8'h01, 15);
    setup(1, 16, 20, 10);
    wr(8'h00, 2);                       // start at E0, returns at N0
    repeat (5) @(negedge clk);          // N5
    wr_now(ra(1, 3), 15);               // write at E6
    rd_now(ra(1, 2), d);                // read at E7, at N7
    check("R1 active duty unchanged after queue", d, 10);
    for (int k = 8; k <= 19; k++) begin
      @(negedge clk);
      if (pwm_o[1]) highs++;
    end
    check("R1 current period keeps old duty", highs, 9);
    @(negedge clk);                     // N20
    highs = 0;
    for (int k = 21; k <= 40; k++) begin
      @(negedge clk);
      if (pwm_o[1]) highs++;
    end
    check("R2 next period uses queued duty", highs, 5);
    rd_now(ra(1, 2), d);
    check("R2 queued duty reads back active", d, 15);
  endtask

  task automatic t_status();
    int d;
    wr(8'h01, 15);
    setup(0, 16, 100, 50);
    setup(2, 16, 100, 50);
    @(negedge clk);
    rd_now(8'h02, d);
    wr_now(8'h00, 5);
    repeat (5) @(negedge clk);
    rd_now(8'h02, d);
    check("R3 enable start sets status", d, 5);
    rd_now(8'h02, d);
    check("R4 read cleared all bits", d, 0);
  endtask

  task automatic t_collide();
    int d;
    wr(8'h01, 15);
    setup(2, 16, 8, 4);
    @(negedge clk);
    wr_now(8'h00, 4);                   // start at E0, at N0
    repeat (3) @(negedge clk);          // N3
    rd_now(8'h02, d);                   // E4 clears
    repeat (3) @(negedge clk);          // N7
    rd_now(8'h02, d);                   // E8 coincides with start
    check("R8 read in start cycle returns prior value", (d >> 2) & 1, 0);
    rd_now(8'h02, d);
    check("R8 start bit survives coincident read", (d >> 2) & 1, 1);
  endtask

  task automatic t_masks();
    int d, h0 = 0, h1 = 0;
    wr(8'h01, 15);
    setup(0, 16, 10, 5);
    setup(1, 16, 10, 5);
    wr(8'h00, 3);
    repeat (4) @(negedge clk);
    wr(8'h01, 1);
    @(negedge clk);
    rd_now(8'h02, d);
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (pwm_o[0]) h0++;
      if (pwm_o[1]) h1++;
    end
    check("R9 stopped channel inactive", h0, 0);
    check("R5 other channel keeps running", h1, 15);
    rd_now(8'h02, d);
    check("R9 stopped channel sets no status", d & 1, 0);
    check("R3 running channel sets status", (d >> 1) & 1, 1);
  endtask

  task automatic t_idle_writes();
    int d;
    wr(8'h01, 15);
    wr(ra(3, 0), 16);
    wr(ra(3, 1), 12);
    wr(ra(3, 2), 7);
    @(negedge clk);
    rd_now(ra(3, 2), d);
    check("R10 direct duty immediate while stopped", d, 7);
    rd_now(ra(3, 1), d);
    check("R10 direct period immediate while stopped", d, 12);
    wr_now(ra(3, 3), 3);
    rd_now(ra(3, 2), d);
    check("R10 queued duty held while stopped", d, 7);
    wr_now(8'h00, 8);
    rd_now(ra(3, 2), d);
    check("R10 queued duty applied at enable", d, 3);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_prescale();
    t_polarity();
    t_limits();
    t_queue();
    t_status();
    t_collide();
    t_masks();
    t_idle_writes();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule